// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is the core of a small programmable logic device. A configuration image, shifted in one bit per clock, programs an AND plane whose product terms combine any mix of true and complemented literals taken from the input bus, the clock pin and the feedback of every output. A fixed OR plane gathers a different number of product terms for each output. Its sum feeds an output macrocell that is either combinational or registered, and either active-high or active-low.

Two product terms are shared by all outputs. One clears every macrocell register at once, without waiting for a clock. The other presets every register on the next rising clock edge. A preload port lets a test write any register state directly. While the configuration port is shifting, the whole array is held inactive. This keeps partly loaded images from driving the outputs or forming live feedback loops.

Top module: `spl_core`

## Requirements
- R1: While rst_ni is low, every macrocell register and every configuration bit is 0. The outputs are therefore all 0, because every term is disabled and every cell is combinational and active-high.
- R2: When cfg_en_i is high, each rising clock edge shifts cfg_bit_i into the top of the configuration chain. After CFG_W shifts, the first bit sent sits at index 0. Configuration layout:
  - Bit 2*o set makes output o registered. Bit 2*o+1 set inverts output o.
  - Term t starts at 2*N_OUT + t*(1+2*N_SIG). At that start, offset 0 is the enable, offset 1+2*s selects signal s true, and offset 2+2*s selects signal s complemented.
  - Signal 0 is clk_i, signal 1+i is in_i[i], and signal 1+N_IN+o is the feedback of output o.
  - Term 0 is the asynchronous clear, term 1 is the synchronous preset, and the terms of the outputs follow in output order.
  - While cfg_en_i is high, every product term reads 0.
- R3: An enabled product term is the AND of its selected literals. An enabled term with no literal selected is 1. A disabled term is 0. A term that selects both polarities of one signal is 0.
- R4: Output o sums exactly 8+2*min(o, 9-o) consecutive product terms (8, 10, 12, 14, 16, 16, 14, 12, 10, 8). The last term of one output has no effect on the next output.
- R5: A combinational output equals its OR sum, inverted when its invert bit is set, with no clock delay.
- R6: A registered cell captures its OR sum on a rising clock edge. Its output is the register value, inverted when its invert bit is set.
- R7: A registered cell feeds back its register value, before inversion. A combinational cell feeds back its output pin value.
- R8: While the clear term is 1, every register is 0 at once, without a clock edge.
- R9: When the preset term is 1, every register becomes 1 on the next rising edge. When the clear term is also 1, the registers stay 0.
- R10: When pl_en_i is high on a rising edge, the registers load pl_data_i. This takes priority over the preset term and the OR sums, but not over the clear term.
- R11: The clock pin can be used as an array literal, so a combinational output can follow clk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock, also array signal 0 |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| in_i | input | N_IN | Dedicated array inputs |
| cfg_en_i | input | 1 | Configuration shift enable; holds the array inactive |
| cfg_bit_i | input | 1 | Serial configuration data |
| pl_en_i | input | 1 | Register preload strobe |
| pl_data_i | input | N_OUT | Register preload values |
| out_o | output | N_OUT | Macrocell output pins |

## Verification
A corrupted configuration bit shows up as a wrong output on the same cycle for a combinational cell, and after the next edge for a registered one. Term-range errors only show when the last term of one output and the first term of the next are both driven, so the bench drives both. A register that feeds back the wrong value stays hidden until a second registered stage copies it, which takes one more edge. The clear term acts between edges, so it is checked without any clock edge in between.

// File: rtl/spl_pkg.sv
package spl_pkg;
  localparam int N_GLOBAL = 2;

  function automatic int pt_of(int o, int n_out, int pt_min, int pt_step);
    int k;
    k = (o < n_out / 2) ? o : n_out - 1 - o;
    return pt_min + pt_step * k;
  endfunction

  function automatic int pt_base(int o, int n_out, int pt_min, int pt_step);
    int b;
    b = N_GLOBAL;
    for (int j = 0; j < o; j++) b += pt_of(j, n_out, pt_min, pt_step);
    return b;
  endfunction
endpackage

// File: rtl/spl_cfg_chain.sv
module spl_cfg_chain #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_o <= '0;
    else if (shift_i) cfg_o <= {bit_i, cfg_o[W-1:1]};
  end
endmodule

// File: rtl/spl_and_plane.sv
module spl_and_plane #(
  parameter int N_SIG = 19,
  parameter int N_PT  = 122,
  localparam int TERM_W = 1 + 2 * N_SIG
) (
  input  logic [N_SIG-1:0]       sig_i,
  input  logic [N_PT*TERM_W-1:0] cfg_i,
  input  logic                   hold_i,
  output logic [N_PT-1:0]        pt_o
);
  for (genvar t = 0; t < N_PT; t++) begin : g_pt
    logic [TERM_W-1:0] fld;
    logic              miss;
    assign fld = cfg_i[t*TERM_W +: TERM_W];
    always_comb begin
      miss = 1'b0;
      for (int s = 0; s < N_SIG; s++)
        miss = miss | (fld[1+2*s] & ~sig_i[s]) | (fld[2+2*s] & sig_i[s]);
    end
    assign pt_o[t] = fld[0] & ~hold_i & ~miss;
  end
endmodule

// File: rtl/spl_macrocell.sv
module spl_macrocell (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic sum_i,
  input  logic preset_i,
  input  logic load_i,
  input  logic load_d_i,
  input  logic reg_mode_i,
  input  logic invert_i,
  output logic q_o,
  output logic pin_o,
  output logic fb_o
);
  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni)       q_o <= 1'b0;
    else if (load_i)   q_o <= load_d_i;
    else if (preset_i) q_o <= 1'b1;
    else               q_o <= sum_i;
  end

  assign pin_o = (reg_mode_i ? q_o : sum_i) ^ invert_i;
  // registered cells feed back the true register state
  assign fb_o  = reg_mode_i ? q_o : pin_o;
endmodule

// File: rtl/spl_core.sv
module spl_core
  import spl_pkg::*;
#(
  parameter int N_IN    = 8,
  parameter int N_OUT   = 10,
  parameter int PT_MIN  = 8,
  parameter int PT_STEP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  in_i,
  input  logic             cfg_en_i,
  input  logic             cfg_bit_i,
  input  logic             pl_en_i,
  input  logic [N_OUT-1:0] pl_data_i,
  output logic [N_OUT-1:0] out_o
);
  localparam int N_SIG  = 1 + N_IN + N_OUT;
  localparam int TERM_W = 1 + 2 * N_SIG;
  localparam int N_PT   = pt_base(N_OUT, N_OUT, PT_MIN, PT_STEP);
  localparam int MC_W   = 2 * N_OUT;
  localparam int CFG_W  = MC_W + N_PT * TERM_W;

  logic [CFG_W-1:0] cfg_q;
  logic [N_SIG-1:0] sig;
  logic [N_PT-1:0]  pt_vec;
  logic [N_OUT-1:0] or_sum, reg_q, fb, pin, reg_mode, inv_mode;
  logic             clr_pt, pre_pt, clr_n;

  spl_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (cfg_en_i),
    .bit_i   (cfg_bit_i),
    .cfg_o   (cfg_q)
  );

  assign sig = {fb, in_i, clk_i};

  spl_and_plane #(.N_SIG(N_SIG), .N_PT(N_PT)) u_and (
    .sig_i  (sig),
    .cfg_i  (cfg_q[CFG_W-1:MC_W]),
    .hold_i (cfg_en_i),
    .pt_o   (pt_vec)
  );

  assign clr_pt = pt_vec[0];
  assign pre_pt = pt_vec[1];
  assign clr_n  = rst_ni & ~clr_pt;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    localparam int BASE = pt_base(o, N_OUT, PT_MIN, PT_STEP);
    localparam int CNT  = pt_of(o, N_OUT, PT_MIN, PT_STEP);
    assign or_sum[o]   = |pt_vec[BASE +: CNT];
    assign reg_mode[o] = cfg_q[2*o];
    assign inv_mode[o] = cfg_q[2*o+1];

    spl_macrocell u_mc (
      .clk_i      (clk_i),
      .clr_ni     (clr_n),
      .sum_i      (or_sum[o]),
      .preset_i   (pre_pt),
      .load_i     (pl_en_i),
      .load_d_i   (pl_data_i[o]),
      .reg_mode_i (reg_mode[o]),
      .invert_i   (inv_mode[o]),
      .q_o        (reg_q[o]),
      .pin_o      (pin[o]),
      .fb_o       (fb[o])
    );
  end

  assign out_o = pin;
endmodule

// File: rtl/spl_core_chk.sv
module spl_core_chk #(
  parameter int N_OUT = 10,
  parameter int N_PT  = 122
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_en_i,
  input logic             cfg_bit_i,
  input logic             cfg_top_i,
  input logic [N_OUT-1:0] reg_mode_i,
  input logic [N_PT-1:0]  pt_i,
  input logic             pl_en_i,
  input logic [N_OUT-1:0] pl_data_i,
  input logic [N_OUT-1:0] reg_q_i,
  input logic [N_OUT-1:0] sum_i,
  input logic             clr_i,
  input logic             pre_i
);
  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_clear_R1: assert (reg_q_i == '0);
  end

  assert_array_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> pt_i == '0);

  assert_chain_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> cfg_top_i == $past(cfg_bit_i));

  assert_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pl_en_i && !pre_i && !clr_i) |=>
      (clr_i || ((reg_q_i ^ $past(sum_i)) & $past(reg_mode_i)) == '0));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> reg_q_i == '0);

  assert_preset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && !pl_en_i && !clr_i) |=> (clr_i || &reg_q_i));

  assert_preload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_en_i && !clr_i) |=> (clr_i || reg_q_i == $past(pl_data_i)));
endmodule

bind spl_core spl_core_chk #(.N_OUT(N_OUT), .N_PT(N_PT)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_en_i   (cfg_en_i),
  .cfg_bit_i  (cfg_bit_i),
  .cfg_top_i  (cfg_q[CFG_W-1]),
  .reg_mode_i (reg_mode),
  .pt_i       (pt_vec),
  .pl_en_i    (pl_en_i),
  .pl_data_i  (pl_data_i),
  .reg_q_i    (reg_q),
  .sum_i      (or_sum),
  .clr_i      (clr_pt),
  .pre_i      (pre_pt)
);

// File: tb/spl_core_tb_top.sv
module spl_core_tb_top;
  localparam int N_IN   = 8;
  localparam int N_OUT  = 10;
  localparam int N_SIG  = 1 + N_IN + N_OUT;
  localparam int TERM_W = 1 + 2 * N_SIG;
  localparam int N_PT   = 122;
  localparam int MC_W   = 2 * N_OUT;
  localparam int CFG_W  = MC_W + N_PT * TERM_W;
  localparam int N_VEC  = 8;
  localparam logic [7:0] TBL_IN [N_VEC] =
    '{8'h00, 8'h03, 8'h04, 8'h0F, 8'h28, 8'h44, 8'h80, 8'hFF};

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic [N_IN-1:0]  in_v;
  logic             cfg_en, cfg_bit, pl_en;
  logic [N_OUT-1:0] pl_data, out_w, expq, nq;
  logic [CFG_W-1:0] img;
  int               checks = 0, failures = 0;
  bit               done = 0;

  always #10 clk_i = ~clk_i;

  spl_core dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_i      (in_v),
    .cfg_en_i  (cfg_en),
    .cfg_bit_i (cfg_bit),
    .pl_en_i   (pl_en),
    .pl_data_i (pl_data),
    .out_o     (out_w)
  );

  function automatic int cnt_of(int o);
    return 8 + 2 * ((o < 5) ? o : 9 - o);
  endfunction
  function automatic int first_of(int o);
    int b = 2;
    for (int j = 0; j < o; j++) b += cnt_of(j);
    return b;
  endfunction
  function automatic int last_of(int o);
    return first_of(o) + cnt_of(o) - 1;
  endfunction
  function automatic int si(int i); return 1 + i; endfunction
  function automatic int sf(int o); return 1 + N_IN + o; endfunction

  function automatic logic [9:0] model_a(logic [7:0] v);
    logic [9:0] r = '0;
    r[0] = (v[0] & v[1]) | ~v[2];
    r[1] = ~v[3];
    r[2] = 1'b1;
    r[4] = v[5];
    r[5] = v[6];
    r[6] = r[0];
    r[9] = v[7] & ~v[0];
    return r;
  endfunction

  task automatic chk(string tag, logic [N_OUT-1:0] act, logic [N_OUT-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #5;
  endtask

  task automatic en_term(int t);
    img[MC_W + t*TERM_W] = 1'b1;
  endtask
  task automatic lit(int t, int s, int comp);
    img[MC_W + t*TERM_W + 1 + 2*s + comp] = 1'b1;
  endtask

  task automatic load_img();
    for (int k = 0; k < CFG_W; k++) begin
      cfg_en  = 1'b1;
      cfg_bit = img[k];
      tick();
    end
    cfg_en  = 1'b0;
    cfg_bit = 1'b0;
    #1;
  endtask

  // reference model of configuration B for one clock edge
  task automatic step_b();
    if (in_v[6] && in_v[7]) nq = '0;
    else if (pl_en)         nq = pl_data;
    else if (in_v[5])       nq = '1;
    else begin
      nq = '0;
      nq[0] = in_v[0];
      nq[1] = in_v[1];
      nq[2] = expq[1];
    end
    tick();
    expq = nq;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; in_v = '0; cfg_en = 1'b0; cfg_bit = 1'b0;
    pl_en = 1'b0; pl_data = '0; expq = '0; img = '0;
    #35;
    chk("R1 outputs in reset", out_w, '0);
    tick();
    rst_ni = 1'b1;
    in_v = 8'hFF;
    tick();
    chk("R1 cleared config after reset", out_w, '0);
    in_v = '0;

    // configuration A: combinational functions
    img = '0;
    en_term(2); lit(2, si(0), 0); lit(2, si(1), 0);
    en_term(3); lit(3, si(2), 1);
    img[2*1+1] = 1'b1;
    en_term(first_of(1)); lit(first_of(1), si(3), 0);
    en_term(first_of(2));
    en_term(first_of(3)); lit(first_of(3), si(4), 0); lit(first_of(3), si(4), 1);
    en_term(last_of(4)); lit(last_of(4), si(5), 0);
    en_term(first_of(5)); lit(first_of(5), si(6), 0);
    en_term(first_of(6)); lit(first_of(6), sf(0), 0);
    en_term(last_of(9)); lit(last_of(9), si(7), 0); lit(last_of(9), si(0), 1);
    load_img();

    for (int i = 0; i < N_VEC; i++) begin
      in_v = TBL_IN[i];
      #1;
      chk($sformatf("R5 comb table vec %0d", i), out_w, model_a(TBL_IN[i]));
    end
    in_v = 8'h20;
    #1;
    chk("R4 last term of out4 only", out_w & 10'h030, 10'h010);
    in_v = 8'h40;
    #1;
    chk("R4 first term of out5 only", out_w & 10'h030, 10'h020);
    in_v = 8'h10;
    #1;
    chk("R3 empty term high, both polarities low", out_w & 10'h00C, 10'h004);
    in_v = 8'h04;
    #1;
    chk("R7 comb feedback of pin", out_w & 10'h041, 10'h000);
    in_v = 8'h00;
    #1;
    chk("R7 comb feedback of pin high", out_w & 10'h041, 10'h041);

    // configuration B: registered cells, clear, preset
    img = '0;
    for (int o = 0; o < N_OUT; o++) img[2*o] = 1'b1;
    img[2*1+1] = 1'b1;
    en_term(0); lit(0, si(6), 0); lit(0, si(7), 0);
    en_term(1); lit(1, si(5), 0);
    en_term(2); lit(2, si(0), 0);
    en_term(first_of(1)); lit(first_of(1), si(1), 0);
    en_term(first_of(2)); lit(first_of(2), sf(1), 0);
    cfg_en = 1'b1;
    cfg_bit = img[0];
    #1;
    chk("R2 array held while shifting", out_w, 10'h002);
    load_img();
    expq = '0;
    chk("R6 idle after load", out_w, expq ^ 10'h002);

    in_v = 8'h01; step_b();
    chk("R6 capture in0", out_w, expq ^ 10'h002);
    in_v = 8'h02; step_b();
    chk("R6 inverted registered cell", out_w, expq ^ 10'h002);
    in_v = 8'h00; step_b();
    chk("R7 register value fed back", out_w, expq ^ 10'h002);
    in_v = 8'h20; step_b();
    chk("R9 preset all", out_w, 10'h3FD);
    in_v = 8'h00; step_b();
    chk("R9 preset released", out_w, expq ^ 10'h002);
    pl_en = 1'b1; pl_data = 10'h2A5; in_v = 8'h20; step_b();
    chk("R10 preload over preset", out_w, 10'h2A7);
    pl_en = 1'b0; pl_data = '0; in_v = 8'hC0;
    #1;
    chk("R8 clear without clock", out_w, 10'h002);
    in_v = 8'hE0; step_b();
    chk("R9 clear beats preset", out_w, 10'h002);
    in_v = 8'h00; step_b();
    chk("R8 after clear", out_w, expq ^ 10'h002);

    // configuration C: clock pin as literal
    img = '0;
    img[2*1+1] = 1'b1;
    en_term(2); lit(2, 0, 0);
    en_term(first_of(1)); lit(first_of(1), 0, 0);
    load_img();
    @(posedge clk_i); #5;
    chk("R11 clock high literal", out_w, 10'h001);
    @(negedge clk_i); #5;
    chk("R11 clock low literal", out_w, 10'h002);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule